// File: doc/BRIEF.md
# DRAM Refresh Scheduler with Owed-Refresh Watermarks

This block decides when a single DRAM rank should be refreshed. An interval counter runs on the DRAM clock and, each time the programmed refresh interval elapses, adds one to a count of refreshes the rank is owed. The count is compared against two programmable thresholds. When it reaches the lower one, a high-priority refresh request is raised. When it reaches the upper one, the request becomes a panic request. Below the lower threshold, a low-urgency opportunistic request is raised once the rank has been idle for a programmed number of cycles. This lets refresh slip into gaps in traffic before it becomes urgent.

A command arbiter outside the block answers the request with a grant. Each accepted grant pays back one owed refresh. It then holds off activates and further refreshes for the programmed refresh execution time. A temperature input, together with a two-bit mode field, can halve the interval and so double the refresh rate. A separate window timer runs from the last refresh. If no refresh is granted within a programmed maximum window, the timer forces a panic request. All parameters are captured while the block is disabled and are held stable while it runs.

Top module: `refresh_sched`

## Requirements
- R1: While enabled, the interval counter advances once per clock. The owed count rises by one on the clock edge that completes each interval. With trefi_i = P and no doubling, the first increment lands on the P-th enabled edge, and further increments follow every P edges.
- R2: ref_prio_o encodes 0 = none, 1 = opportunistic, 2 = high, 3 = panic. ref_prio_o is never 0 while ref_req_o is 1. A request is raised at high priority on the edge after the owed count, if nonzero, reaches hp_wm_i.
- R3: A request is raised to panic priority on the edge after the owed count, if nonzero, reaches panic_wm_i.
- R4: The idle counter counts consecutive cycles of rank_idle_i. Once it reaches idle_lim_i while the owed count is below hp_wm_i, an opportunistic request (priority 1) is raised on the following edge, even when nothing is owed. With the rank busy and the owed count below hp_wm_i, no request is raised.
- R5: A grant is accepted on an edge where ref_req_o and ref_gnt_i are both 1. For trfc_i cycles after that edge, block_act_o is 1 and ref_req_o is 0.
- R6: Once raised, a request stays asserted until it is granted, and its priority never decreases. An opportunistic request is kept even if the rank stops being idle.
- R7: dbl_mode_i selects doubling. 00 doubles only while temp_hot_i is 1. 01 always doubles. 10 never doubles. 11 behaves as 00. Doubling means an interval of trefi_i/2 cycles.
- R8: Each accepted grant lowers the owed count by one. The count saturates at 15 and never goes below 0.
- R9: After reset, and on the edge after en_i falls, ref_req_o and block_act_o are 0 and every counter is cleared. Parameters are sampled only while en_i is 0.
- R10: A window timer counts cycles since enabling or since the last accepted grant. When it reaches max_win_i·1024 − 100, a panic request is raised on the following edge.
- R11: The idle counter restarts from zero whenever rank_idle_i is 0 and whenever a grant is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DRAM clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; parameters are sampled while low |
| trefi_i | input | 16 | Refresh interval in clocks |
| trfc_i | input | 9 | Refresh execution time in clocks |
| hp_wm_i | input | 4 | Owed count that makes a request high priority |
| panic_wm_i | input | 4 | Owed count that makes a request panic |
| idle_lim_i | input | 8 | Idle cycles that open an opportunistic refresh |
| max_win_i | input | 7 | Maximum no-refresh window in units of 1024 clocks |
| dbl_mode_i | input | 2 | Refresh-rate doubling mode |
| temp_hot_i | input | 1 | DRAM reports warm or hot |
| rank_idle_i | input | 1 | Rank has no pending traffic |
| ref_gnt_i | input | 1 | Refresh grant from the command arbiter |
| ref_req_o | output | 1 | Refresh request |
| ref_prio_o | output | 2 | Request priority |
| block_act_o | output | 1 | Activates and refreshes are held off |

## Verification
The bench lets the request climb from high to panic while it is still held. A design that latched the first priority would grant at high priority instead of panic. It also pays back an opportunistic refresh when nothing is owed. A count that wrapped below zero would come back as a panic request, and one that overflowed above 15 would come back as a high request where panic is expected. Every doubling mode is run, both temperature states are tried for the ambiguous encodings, and an early or late request shows the wrong interval. The bench also runs the window timeout and the edge where the block-out time ends, where an off-by-one in either counter moves the request by a cycle.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  typedef enum logic [1:0] {
    PRIO_NONE  = 2'd0,
    PRIO_OPP   = 2'd1,
    PRIO_HIGH  = 2'd2,
    PRIO_PANIC = 2'd3
  } prio_e;

  localparam logic [1:0] DBL_TEMP   = 2'b00;
  localparam logic [1:0] DBL_ALWAYS = 2'b01;
  localparam logic [1:0] DBL_NEVER  = 2'b10;
endpackage

// File: rtl/refresh_interval.sv
module refresh_interval #(
  parameter int PER_W = 16,
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] owed_o
);
  localparam logic [CNT_W-1:0] OWED_MAX = '1;

  logic [PER_W-1:0] int_cnt_q;
  logic [PER_W-1:0] per_eff;
  logic             tick;
  logic [CNT_W-1:0] owed_q;

  assign per_eff = (period_i == '0) ? PER_W'(1) : period_i;
  assign tick    = en_i && (int_cnt_q >= per_eff - PER_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    int_cnt_q <= '0;
    else if (!en_i) int_cnt_q <= '0;
    else if (tick)  int_cnt_q <= '0;
    else            int_cnt_q <= int_cnt_q + PER_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    owed_q <= '0;
    else if (!en_i) owed_q <= '0;
    else begin
      unique case ({tick, dec_i})
        2'b10:   if (owed_q != OWED_MAX) owed_q <= owed_q + CNT_W'(1);
        2'b01:   if (owed_q != '0)       owed_q <= owed_q - CNT_W'(1);
        default: owed_q <= owed_q;  // tick and payback cancel
      endcase
    end
  end

  assign owed_o = owed_q;
endmodule

// File: rtl/refresh_window.sv
module refresh_window #(
  parameter int IDLE_W = 8,
  parameter int WCNT_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rank_idle_i,
  input  logic              clr_i,
  input  logic [IDLE_W-1:0] idle_lim_i,
  input  logic [WCNT_W-1:0] win_lim_i,
  output logic              opp_ok_o,
  output logic              win_hit_o
);
  logic [IDLE_W-1:0] idle_q;
  logic [WCNT_W-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             idle_q <= '0;
    else if (!en_i || !rank_idle_i || clr_i) idle_q <= '0;
    else if (idle_q != '1)                   idle_q <= idle_q + IDLE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              win_q <= '0;
    else if (!en_i || clr_i)  win_q <= '0;
    else if (win_q != '1)     win_q <= win_q + WCNT_W'(1);
  end

  assign opp_ok_o  = idle_q >= idle_lim_i;
  assign win_hit_o = win_q >= win_lim_i;
endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter
  import refresh_sched_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int RFC_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] owed_i,
  input  logic [CNT_W-1:0] hp_wm_i,
  input  logic [CNT_W-1:0] panic_wm_i,
  input  logic             opp_ok_i,
  input  logic             win_hit_i,
  input  logic             gnt_i,
  input  logic [RFC_W-1:0] trfc_i,
  output logic             req_o,
  output prio_e            prio_o,
  output logic             blk_o,
  output logic             gnt_acc_o
);
  logic             req_q;
  prio_e            prio_q;
  prio_e            want;
  logic [RFC_W-1:0] rfc_q;
  logic             owed_nz;

  assign owed_nz   = owed_i != '0;
  assign gnt_acc_o = req_q && gnt_i;
  assign blk_o     = rfc_q != '0;

  always_comb begin
    if ((owed_nz && owed_i >= panic_wm_i) || win_hit_i) want = PRIO_PANIC;
    else if (owed_nz && owed_i >= hp_wm_i)              want = PRIO_HIGH;
    else if (opp_ok_i && owed_i < hp_wm_i)              want = PRIO_OPP;
    else                                                want = PRIO_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rfc_q <= '0;
    else if (!en_i)      rfc_q <= '0;
    else if (gnt_acc_o)  rfc_q <= trfc_i;
    else if (blk_o)      rfc_q <= rfc_q - RFC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      prio_q <= PRIO_NONE;
    end else if (!en_i || gnt_acc_o || blk_o) begin
      req_q  <= 1'b0;
      prio_q <= PRIO_NONE;
    end else if (req_q) begin
      if (want > prio_q) prio_q <= want;  // escalate only
    end else if (want != PRIO_NONE) begin
      req_q  <= 1'b1;
      prio_q <= want;
    end
  end

  assign req_o  = req_q;
  assign prio_o = prio_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int PER_W      = 16,
  parameter int RFC_W      = 9,
  parameter int WM_W       = 4,
  parameter int IDLE_W     = 8,
  parameter int WIN_W      = 7,
  parameter int WIN_SHIFT  = 10,
  parameter int WIN_MARGIN = 100
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PER_W-1:0]  trefi_i,
  input  logic [RFC_W-1:0]  trfc_i,
  input  logic [WM_W-1:0]   hp_wm_i,
  input  logic [WM_W-1:0]   panic_wm_i,
  input  logic [IDLE_W-1:0] idle_lim_i,
  input  logic [WIN_W-1:0]  max_win_i,
  input  logic [1:0]        dbl_mode_i,
  input  logic              temp_hot_i,
  input  logic              rank_idle_i,
  input  logic              ref_gnt_i,
  output logic              ref_req_o,
  output logic [1:0]        ref_prio_o,
  output logic              block_act_o
);
  localparam int WCNT_W = WIN_W + WIN_SHIFT;
  localparam logic [WCNT_W-1:0] MARGIN = WCNT_W'(WIN_MARGIN);

  logic [PER_W-1:0]  trefi_q;
  logic [RFC_W-1:0]  trfc_q;
  logic [WM_W-1:0]   hp_q, pan_q;
  logic [IDLE_W-1:0] idle_lim_q;
  logic [WIN_W-1:0]  win_q;
  logic [1:0]        dbl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trefi_q    <= PER_W'(4100);
      trfc_q     <= RFC_W'(180);
      hp_q       <= WM_W'(8);
      pan_q      <= WM_W'(9);
      idle_lim_q <= IDLE_W'(15);
      win_q      <= WIN_W'(35);
      dbl_q      <= DBL_TEMP;
    end else if (!en_i) begin
      trefi_q    <= trefi_i;
      trfc_q     <= trfc_i;
      hp_q       <= hp_wm_i;
      pan_q      <= panic_wm_i;
      idle_lim_q <= idle_lim_i;
      win_q      <= max_win_i;
      dbl_q      <= dbl_mode_i;
    end
  end

  logic             dbl_on;
  logic [PER_W-1:0] period;
  logic [WCNT_W-1:0] win_full, win_lim;

  always_comb begin
    unique case (dbl_q)
      DBL_ALWAYS: dbl_on = 1'b1;
      DBL_NEVER:  dbl_on = 1'b0;
      default:    dbl_on = temp_hot_i;  // 00 and reserved 11
    endcase
  end

  assign period   = dbl_on ? (trefi_q >> 1) : trefi_q;
  assign win_full = {win_q, {WIN_SHIFT{1'b0}}};
  assign win_lim  = (win_full > MARGIN) ? (win_full - MARGIN) : WCNT_W'(1);

  logic [WM_W-1:0] owed;
  logic            opp_ok, win_hit, gnt_acc, blk;
  prio_e           prio;

  refresh_interval #(.PER_W(PER_W), .CNT_W(WM_W)) u_interval (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .period_i (period),
    .dec_i    (gnt_acc),
    .owed_o   (owed)
  );

  refresh_window #(.IDLE_W(IDLE_W), .WCNT_W(WCNT_W)) u_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .rank_idle_i (rank_idle_i),
    .clr_i       (gnt_acc),
    .idle_lim_i  (idle_lim_q),
    .win_lim_i   (win_lim),
    .opp_ok_o    (opp_ok),
    .win_hit_o   (win_hit)
  );

  refresh_arbiter #(.CNT_W(WM_W), .RFC_W(RFC_W)) u_arbiter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .owed_i     (owed),
    .hp_wm_i    (hp_q),
    .panic_wm_i (pan_q),
    .opp_ok_i   (opp_ok),
    .win_hit_i  (win_hit),
    .gnt_i      (ref_gnt_i),
    .trfc_i     (trfc_q),
    .req_o      (ref_req_o),
    .prio_o     (prio),
    .blk_o      (blk),
    .gnt_acc_o  (gnt_acc)
  );

  assign ref_prio_o  = prio;
  assign block_act_o = blk;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int RFC_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [RFC_W-1:0] trfc_i,
  input logic             ref_gnt_i,
  input logic             ref_req_o,
  input logic [1:0]       ref_prio_o,
  input logic             block_act_o
);
  AST_PRIO_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_req_o |-> ref_prio_o != 2'd0); // R2

  AST_BLOCK_AFTER_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ref_req_o && ref_gnt_i && trfc_i != '0) |=> block_act_o); // R5

  AST_NO_REQ_IN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_act_o |-> !ref_req_o); // R5

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ref_req_o && !ref_gnt_i) |=> ref_req_o); // R6

  AST_PRIO_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ref_req_o && !ref_gnt_i) |=> ref_prio_o >= $past(ref_prio_o)); // R6

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!ref_req_o && !block_act_o)); // R9
endmodule

bind refresh_sched refresh_sched_chk #(.RFC_W(RFC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .trfc_i      (trfc_i),
  .ref_gnt_i   (ref_gnt_i),
  .ref_req_o   (ref_req_o),
  .ref_prio_o  (ref_prio_o),
  .block_act_o (block_act_o)
);

// File: tb/refresh_sched_test.sv
`timescale 1ns/1ps
module refresh_sched_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [15:0] trefi_i = 16'd20;
  logic [8:0]  trfc_i = 9'd5;
  logic [3:0]  hp_wm_i = 4'd2;
  logic [3:0]  panic_wm_i = 4'd3;
  logic [7:0]  idle_lim_i = 8'd4;
  logic [6:0]  max_win_i = 7'd127;
  logic [1:0]  dbl_mode_i = 2'b10;
  logic        temp_hot_i = 1'b0;
  logic        rank_idle_i = 1'b0;
  logic        ref_gnt_i = 1'b0;
  logic        ref_req_o;
  logic [1:0]  ref_prio_o;
  logic        block_act_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  int exp_q[$];

  always #2 clk_i = ~clk_i;  // 250 MHz

  refresh_sched uut (.*);

  always @(posedge clk_i) cyc <= en_i ? cyc + 1 : 0;

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk_i);
  endtask

  // request/priority as one value: 0 when idle, else 4+prio
  function automatic int rq();
    return ref_req_o ? 4 + int'(ref_prio_o) : 0;
  endfunction

  task automatic start(input int trefi, input int trfc, input int hp, input int pan,
                       input int idl, input int win, input logic [1:0] dbl, input logic hot);
    en_i = 1'b0;
    @(negedge clk_i);
    trefi_i = 16'(trefi); trfc_i = 9'(trfc); hp_wm_i = 4'(hp); panic_wm_i = 4'(pan);
    idle_lim_i = 8'(idl); max_win_i = 7'(win); dbl_mode_i = dbl; temp_hot_i = hot;
    repeat (3) @(negedge clk_i);
    en_i = 1'b1;
  endtask

  // driver: push expected grant priority, pulse grant for one cycle
  task automatic grant(input int exp_prio);
    exp_q.push_back(exp_prio);
    ref_gnt_i = 1'b1;
    @(negedge clk_i);
    ref_gnt_i = 1'b0;
  endtask

  // monitor: priority seen at each accepted grant
  always @(negedge clk_i) begin
    #1;
    if (ref_gnt_i && ref_req_o) begin
      if (exp_q.size() == 0) check("R6 unexpected grant", int'(ref_prio_o), -1);
      else check("R6 prio at grant", int'(ref_prio_o), exp_q.pop_front());
    end
  end

  task automatic dbl_case(input logic [1:0] mode, input logic hot, input bit halved, input string tag);
    start(20, 5, 1, 3, 200, 127, mode, hot);
    if (halved) begin
      wait_cyc(10); check({tag, " before half interval"}, rq(), 0);
      wait_cyc(11); check({tag, " after half interval"}, rq(), 6);
    end else begin
      wait_cyc(11); check({tag, " no early tick"}, rq(), 0);
      wait_cyc(21); check({tag, " full interval"}, rq(), 6);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R9 reset req", rq(), 0);
    check("R9 reset block", int'(block_act_o), 0);
    rst_ni = 1'b1;

    // watermarks, escalation, block-out
    start(20, 5, 2, 3, 4, 127, 2'b10, 1'b0);
    wait_cyc(25); check("R4 busy below hp no req", rq(), 0);
    wait_cyc(40); check("R1 second tick not yet visible", rq(), 0);
    wait_cyc(41); check("R2 high at hp", rq(), 6);
    wait_cyc(60); check("R6 still high before third tick", rq(), 6);
    wait_cyc(61); check("R3 panic at wm", rq(), 7);
    grant(3);
    wait_cyc(62); check("R5 req drops at grant", rq(), 0);
    check("R5 block starts", int'(block_act_o), 1);
    wait_cyc(66); check("R5 block last cycle", int'(block_act_o), 1);
    wait_cyc(67); check("R5 block ends", int'(block_act_o), 0);
    check("R5 no req at block end", rq(), 0);
    wait_cyc(68); check("R8 owed 2 after one grant", rq(), 6);
    grant(2);
    wait_cyc(76); check("R8 owed 1 below hp", rq(), 0);

    // opportunistic
    rank_idle_i = 1'b1;
    start(20, 5, 2, 3, 4, 127, 2'b10, 1'b0);
    wait_cyc(4); check("R4 idle limit not reached", rq(), 0);
    wait_cyc(5); check("R4 opportunistic with nothing owed", rq(), 5);
    rank_idle_i = 1'b0;
    wait_cyc(7); check("R6 opp held after busy", rq(), 5);
    grant(1);
    wait_cyc(14); check("R8 no underflow after opp", rq(), 0);
    rank_idle_i = 1'b1;
    wait_cyc(18); check("R11 idle restarted after grant", rq(), 0);
    wait_cyc(19); check("R11 opp after fresh idle run", rq(), 5);
    rank_idle_i = 1'b0;
    en_i = 1'b0;
    @(negedge clk_i);
    check("R9 disable clears req", rq(), 0);

    // doubling modes
    dbl_case(2'b00, 1'b1, 1, "R7 m00 hot");
    dbl_case(2'b00, 1'b0, 0, "R7 m00 cool");
    dbl_case(2'b01, 1'b0, 1, "R7 m01");
    dbl_case(2'b10, 1'b1, 0, "R7 m10 hot");
    dbl_case(2'b11, 1'b1, 1, "R7 m11 hot");
    dbl_case(2'b11, 1'b0, 0, "R7 m11 cool");

    // saturation
    start(4, 20, 1, 15, 200, 127, 2'b10, 1'b0);
    wait_cyc(5);  check("R2 high from owed 1", rq(), 6);
    wait_cyc(60); check("R8 owed 14 still high", rq(), 6);
    wait_cyc(61); check("R3 panic at owed 15", rq(), 7);
    wait_cyc(100);
    grant(3);
    wait_cyc(121); check("R5 long block holds req", rq(), 0);
    wait_cyc(122); check("R8 saturated count back at 15", rq(), 7);

    // no-refresh window
    start(2000, 5, 2, 3, 4, 1, 2'b10, 1'b0);
    wait_cyc(924); check("R10 window not reached", rq(), 0);
    wait_cyc(925); check("R10 window forces panic", rq(), 7);
    grant(3);
    wait_cyc(1000); check("R10 window restarted by grant", rq(), 0);

    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R6 all grants observed", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule